// File: doc/BRIEF.md
# Shared IO Window Arbiter

Several CPUs, each with a private 1024-byte IO space, share one small peripheral window at the top 64 bytes of that space. The block decides which CPU owns the window at any moment. The window's read and write strobes, offset and write data are forwarded from the owner only, and read data from the window goes back to the owner only.

Software takes ownership by writing a claim command to a control register in its private range. It then polls the same register until the bit at its own CPU number is set. Writing a release command hands the window on. Claims never stall a bus. Pending claims are latched per CPU. A free window goes to the lowest-numbered claimant. With nothing claimed, CPU 0 owns the window by default. A second read-only register tells each CPU its own number, so identical code can run on every CPU.

The window is at byte addresses 960..1023 and is chosen by address bits [9:6] all set. The control register and the ID register are parameters. Per-CPU buses are flat vectors: CPU k uses slice k of each.

Top module: `shared_io_arbiter`

## Requirements
- R1: A read of the ID register (address ID_ADDR, default 0x304) by CPU k returns k in the same cycle.
- R2: A read of the control register (CTRL_ADDR, default 0x300) returns the grant bitmap: bit k is set when CPU k owns the window, and all other bits are zero. The `grant` output carries the same bitmap.
- R3: Writing value 1 to the control register claims the window. If the window is unheld, or held by a CPU that releases in that cycle, the grant changes at the clock edge that takes the write.
- R4: When several claims meet an unheld window in the same cycle, the lowest-numbered claimant is granted. The others stay latched as pending.
- R5: While a CPU holds the window, its grant does not change, whatever others claim. When it writes value 2 (release), the grant passes at that edge to the lowest-numbered pending claimant. A claim by the current holder has no effect.
- R6: With no claim held or pending, the window belongs to CPU 0, and grant reads as 1.
- R7: A release written by a CPU that does not hold the window only withdraws that CPU's pending claim. The owner is unchanged.
- R8: Writes of any value other than 1 or 2 to the control register change neither the grant nor any pending claim.
- R9: Owner reads and writes at addresses 960..1023 drive `sh_rd`/`sh_wr`, `sh_addr` (address bits [5:0]) and `sh_wdata` in the same cycle, and the owner receives `sh_rdata`. With no window strobe, `sh_addr` and `sh_wdata` are zero.
- R10: A window read by a non-owner returns zero, and a window write by a non-owner raises no shared strobe.
- R11: A synchronous `cpu_rst[k]` withdraws CPU k's pending claim. If CPU k holds the window, it also releases it, exactly as a release would.
- R12: Reads of any other private address return zero and touch neither the shared strobes nor the arbitration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| cpu_rst | input | NCPU | Per-CPU synchronous reset |
| cpu_addr | input | NCPU*ADDR_W | Per-CPU IO byte address |
| cpu_rd | input | NCPU | Per-CPU read strobe |
| cpu_wr | input | NCPU | Per-CPU write strobe |
| cpu_wdata | input | NCPU*DATA_W | Per-CPU write data |
| cpu_rdata | output | NCPU*DATA_W | Per-CPU read data from the block |
| grant | output | NCPU | One-hot owner bitmap |
| sh_rd | output | 1 | Shared window read strobe |
| sh_wr | output | 1 | Shared window write strobe |
| sh_addr | output | 6 | Offset inside the shared window |
| sh_wdata | output | DATA_W | Write data to the shared window |
| sh_rdata | input | DATA_W | Read data from the shared window |

## Verification
The hardest situation to reach is a release by the holder while other claims are pending. The hand-over must skip the released CPU and pick the lowest pending claimant, not the order of arrival. The bench uses three CPUs so that both pending claims can be built up behind a holder. It also drives a same-cycle tie on an unheld window, and it resets a holder while another claim is pending. A behavioural model checks every port on every cycle, including cycles where the owner and a non-owner hit the window at once.

// File: rtl/shared_io_arbiter.sv
module shared_io_arbiter #(
  parameter int NCPU        = 2,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int WIN_BYTES   = 64,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h300,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 'h304,
  parameter int CMD_CLAIM   = 1,
  parameter int CMD_RELEASE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCPU-1:0]          cpu_rst,
  input  logic [NCPU*ADDR_W-1:0]   cpu_addr,
  input  logic [NCPU-1:0]          cpu_rd,
  input  logic [NCPU-1:0]          cpu_wr,
  input  logic [NCPU*DATA_W-1:0]   cpu_wdata,
  output logic [NCPU*DATA_W-1:0]   cpu_rdata,
  output logic [NCPU-1:0]          grant,
  output logic                     sh_rd,
  output logic                     sh_wr,
  output logic [$clog2(WIN_BYTES)-1:0] sh_addr,
  output logic [DATA_W-1:0]        sh_wdata,
  input  logic [DATA_W-1:0]        sh_rdata
);
  localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int OW = $clog2(WIN_BYTES);
  localparam logic [ADDR_W:0] WIN_BASE = (ADDR_W+1)'((1 << ADDR_W) - WIN_BYTES);

  logic [IW-1:0]   owner, owner_n;
  logic            held, held_n, free;
  logic [NCPU-1:0] pend, pend_n, cand;
  logic [NCPU-1:0] claim_v, rel_v, in_win, win_rd, win_wr;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d, r;
    logic              is_ctrl;
    assign a         = cpu_addr[i*ADDR_W +: ADDR_W];
    assign d         = cpu_wdata[i*DATA_W +: DATA_W];
    assign in_win[i] = {1'b0, a} >= WIN_BASE;
    assign is_ctrl   = a == CTRL_ADDR;
    assign claim_v[i] = cpu_wr[i] && is_ctrl && d == DATA_W'(CMD_CLAIM);
    assign rel_v[i]   = cpu_wr[i] && is_ctrl && d == DATA_W'(CMD_RELEASE);
    assign win_rd[i]  = cpu_rd[i] && in_win[i];
    assign win_wr[i]  = cpu_wr[i] && in_win[i];
    assign r = !cpu_rd[i]       ? '0 :
               a == ID_ADDR     ? DATA_W'(i) :
               is_ctrl          ? DATA_W'(grant) :
               in_win[i] && owner == IW'(i) ? sh_rdata : '0;
    assign cpu_rdata[i*DATA_W +: DATA_W] = r;

    assert_nonowner_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd[i] && in_win[i] && owner != IW'(i)) |-> r == '0);
    assert_nonowner_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr[i] && owner != IW'(i) && !win_wr[owner]) |-> !sh_wr);
  end

  assign grant = NCPU'(1) << owner;
  assign free  = !held || rel_v[owner] || cpu_rst[owner];
  assign cand  = (pend | (claim_v & ~(held ? grant : '0))) & ~rel_v & ~cpu_rst;

  always_comb begin
    pend_n  = cand;
    owner_n = owner;
    held_n  = held;
    if (free) begin
      held_n  = 1'b0;
      owner_n = '0;
      for (int k = NCPU-1; k >= 0; k--)
        if (cand[k]) begin
          owner_n = IW'(k);
          held_n  = 1'b1;
        end
      if (held_n) pend_n[owner_n] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      owner <= '0;
      held  <= 1'b0;
      pend  <= '0;
    end else begin
      owner <= owner_n;
      held  <= held_n;
      pend  <= pend_n;
    end

  assign sh_rd    = win_rd[owner];
  assign sh_wr    = win_wr[owner];
  assign sh_addr  = (sh_rd || sh_wr) ? cpu_addr[int'(owner)*ADDR_W +: OW] : '0;
  assign sh_wdata = sh_wr ? cpu_wdata[int'(owner)*DATA_W +: DATA_W] : '0;

  assert_holder_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rel_v[owner] && !cpu_rst[owner]) |=> (held && owner == $past(owner)));
  assert_default_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> owner == '0);
  assert_tie_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && pend == '0 && claim_v != '0) |=> grant == $past(claim_v & (~claim_v + 1'b1)));
  assert_reset_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cpu_rst[owner]) |=> !(held && owner == $past(owner)));
endmodule

// File: tb/tb_shared_io_arbiter.sv
module tb_shared_io_arbiter;
  localparam int N = 3;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CTRL = 'h300;
  localparam int IDR  = 'h304;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cpu_rst = '0, rd = '0, wr = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N*DW-1:0] rdata;
  logic [N-1:0] grant;
  logic sh_rd, sh_wr;
  logic [5:0] sh_addr;
  logic [DW-1:0] sh_wdata, sh_rdata;

  int checks = 0, errors = 0;
  int m_owner = 0;
  bit m_held = 0;
  bit m_pend [N];
  string ph = "reset";

  always #10 clk = ~clk;
  assign sh_rdata = 32'hC0DE0000 | 32'(sh_addr);

  shared_io_arbiter #(.NCPU(N)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst), .cpu_addr(addr), .cpu_rd(rd),
    .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(rdata), .grant(grant),
    .sh_rd(sh_rd), .sh_wr(sh_wr), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
    .sh_rdata(sh_rdata));

  function automatic int a_of(int c); return int'(addr[c*AW +: AW]); endfunction
  function automatic logic [31:0] d_of(int c); return wdata[c*DW +: DW]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = 0; m_held = 0;
      for (int i = 0; i < N; i++) m_pend[i] = 0;
    end else begin
      bit p [N];
      bit fr;
      fr = !m_held;
      for (int i = 0; i < N; i++) begin
        bit cl, rl;
        cl = wr[i] && a_of(i) == CTRL && d_of(i) == 1;
        rl = wr[i] && a_of(i) == CTRL && d_of(i) == 2;
        if (i == m_owner && (rl || cpu_rst[i])) fr = 1;
        p[i] = (m_pend[i] || (cl && !(m_held && m_owner == i))) && !rl && !cpu_rst[i];
      end
      if (fr) begin
        m_held = 0; m_owner = 0;
        for (int i = 0; i < N; i++)
          if (p[i] && !m_held) begin m_owner = i; m_held = 1; p[i] = 0; end
      end
      for (int i = 0; i < N; i++) m_pend[i] = p[i];
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s): got %h expected %h", req, ph, got, exp);
    end
  endtask

  task automatic compare(string req);
    int o = m_owner;
    bit r, w;
    r = rd[o] && a_of(o) >= 960;
    w = wr[o] && a_of(o) >= 960;
    chk(req, 32'(grant), 32'(1) << m_owner);
    chk(req, 32'(sh_rd), 32'(r));
    chk(req, 32'(sh_wr), 32'(w));
    chk(req, 32'(sh_addr), (r || w) ? 32'(a_of(o) & 63) : 0);
    chk(req, sh_wdata, w ? d_of(o) : 0);
    for (int c = 0; c < N; c++) begin
      logic [31:0] e;
      int a = a_of(c);
      if (!rd[c]) e = 0;
      else if (a == IDR) e = c;
      else if (a == CTRL) e = 32'(1) << m_owner;
      else if (a >= 960) e = (c == m_owner) ? (32'hC0DE0000 | 32'(a & 63)) : 0;
      else e = 0;
      chk(req, rdata[c*DW +: DW], e);
    end
  endtask

  task automatic acc(int c, bit r, bit w, int a, logic [31:0] d);
    rd[c] = r; wr[c] = w;
    addr[c*AW +: AW] = AW'(a);
    wdata[c*DW +: DW] = d;
  endtask

  task automatic tick(string req);
    #2 compare(req);
    @(posedge clk);
    @(negedge clk);
    rd = '0; wr = '0; cpu_rst = '0; addr = '0; wdata = '0;
  endtask

  task automatic poll(string req);
    for (int c = 0; c < N; c++) acc(c, 1, 0, CTRL, 0);
    tick(req);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    ph = "reset";
    compare("R6");
    rst_n = 1;
    @(negedge clk);
    ph = "id";
    for (int c = 0; c < N; c++) acc(c, 1, 0, IDR, 0);
    tick("R1");
    poll("R2");
    ph = "claim1";
    acc(1, 0, 1, CTRL, 1); tick("R3");
    poll("R3");
    ph = "window";
    acc(1, 0, 1, 980, 32'h1234_5678); acc(0, 0, 1, 1000, 32'hDEAD_BEEF); tick("R9");
    acc(1, 1, 0, 1023, 0); acc(0, 1, 0, 962, 0); tick("R10");
    acc(0, 0, 1, 970, 32'h55); tick("R10");
    acc(2, 1, 0, 960, 0); tick("R10");
    ph = "queue";
    acc(2, 0, 1, CTRL, 1); tick("R5");
    acc(0, 0, 1, CTRL, 1); acc(1, 0, 1, CTRL, 1); tick("R5");
    poll("R5");
    acc(1, 0, 1, CTRL, 2); tick("R5");
    poll("R5");
    acc(0, 1, 0, 990, 0); tick("R9");
    acc(0, 0, 1, CTRL, 2); tick("R5");
    poll("R5");
    acc(2, 0, 1, CTRL, 2); tick("R6");
    poll("R6");
    ph = "tie";
    acc(2, 0, 1, CTRL, 1); acc(1, 0, 1, CTRL, 1); tick("R4");
    poll("R4");
    ph = "nonholder";
    acc(2, 0, 1, CTRL, 2); tick("R7");
    poll("R7");
    acc(1, 0, 1, CTRL, 2); tick("R7");
    poll("R7");
    ph = "badcmd";
    acc(1, 0, 1, CTRL, 3); acc(2, 0, 1, CTRL, 0); tick("R8");
    poll("R8");
    acc(2, 0, 1, CTRL, 32'h101); tick("R8");
    poll("R8");
    ph = "cpureset";
    acc(2, 0, 1, CTRL, 1); tick("R11");
    acc(1, 0, 1, CTRL, 1); acc(0, 0, 1, CTRL, 1); tick("R11");
    cpu_rst[2] = 1; tick("R11");
    poll("R11");
    cpu_rst[1] = 1; tick("R11");
    poll("R11");
    cpu_rst[0] = 1; tick("R11");
    poll("R11");
    ph = "private";
    acc(0, 1, 0, 100, 0); acc(1, 1, 0, 959, 0); acc(2, 1, 1, 4, 32'h1); tick("R12");
    acc(0, 0, 1, CTRL + 4, 1); tick("R12");
    poll("R12");
    ph = "reset2";
    acc(1, 0, 1, CTRL, 1); tick("R3");
    rst_n = 0; #2 compare("R6");
    @(negedge clk); rst_n = 1;
    poll("R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule